// File: doc/BRIEF.md
# Quadrant-Rotation Frequency Detector

This block is the digital decision core of a half-rate quadricorrelator frequency detector for a clock and data recovery loop. Each time a data transition arrives, the sampled levels of four quadrature clock phases identify which quarter of the half clock period the edge fell in. That quarter arrives as a 2-bit Gray-coded quadrant together with a one-cycle strobe. The block keeps the last quadrant it saw. It emits a frequency correction only when consecutive quadrants step across the reference-edge boundary, which lies between quadrant IV and quadrant I.

When the loop is locked, or when the data holds a long run of identical bits, the quadrant does not change and the detector stays silent. When the oscillator runs slow or fast, the quadrant walks steadily in one direction. Every wrap through the boundary then produces a single-cycle pulse on the down or up output, and these pulses drive a dedicated frequency charge pump. A two-quadrant jump cannot be resolved to a direction, so it is taken as the new state without producing a pulse.

Top module: `fdq_freq_det`

## Requirements
- R1: While reset is high, and in the cycle after it is released, both `freq_up` and `freq_dn` are low.
- R2: The first strobe after reset only loads the quadrant and never pulses, whatever code it carries, including I (00) or IV (10).
- R3: A strobe carrying quadrant I (00) while the stored quadrant is IV (10) drives `freq_dn` high for exactly the one cycle after the strobe edge.
- R4: A strobe carrying quadrant IV (10) while the stored quadrant is I (00) drives `freq_up` high for exactly the one cycle after the strobe edge.
- R5: Adjacent moves that do not cross the boundary (I↔II, II↔III, III↔IV, with II=01 and III=11) produce no pulse.
- R6: A two-quadrant jump (I↔III or II↔IV) produces no pulse, and the new quadrant becomes the stored state.
- R7: A strobe that repeats the stored quadrant produces no pulse.
- R8: While the strobe is low, the quadrant input is ignored and the stored state is unchanged.
- R9: `freq_up` and `freq_dn` are never high together, and over a steady rotation the number of pulses equals the number of boundary crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_vld | input | 1 | Strobe: a data edge was sampled this cycle |
| quad_code | input | 2 | Gray-coded quadrant of that edge (I=00, II=01, III=11, IV=10) |
| freq_up | output | 1 | One-cycle request to raise oscillator frequency |
| freq_dn | output | 1 | One-cycle request to lower oscillator frequency |

## Verification
The only state is the stored quadrant and the flag that marks it as valid. A wrong stored quadrant therefore stays hidden until the next strobe whose move involves the boundary. At that point it shows as a missing pulse, an extra pulse, or a pulse in the wrong direction on the output, one cycle after that strobe. The directed sequences put each suspect state next to a boundary move, so that an error surfaces within one or two strobes. Jump and idle cases are followed by such a probe move.

// File: rtl/fdq_pkg.sv
package fdq_pkg;
   typedef enum logic [1:0] {
      Q_I   = 2'b00,
      Q_II  = 2'b01,
      Q_III = 2'b11,
      Q_IV  = 2'b10
   } quad_e;

   typedef enum logic [1:0] {
      MV_HOLD = 2'd0,
      MV_FWD  = 2'd1,
      MV_JUMP = 2'd2,
      MV_BACK = 2'd3
   } move_e;

   // Gray quadrant to rotation index 0..3
   function automatic logic [1:0] quad_idx(input logic [1:0] g);
      return {g[1], g[1] ^ g[0]};
   endfunction
endpackage

// File: rtl/fdq_state.sv
module fdq_state
   import fdq_pkg::*;
#(
   parameter int QW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [QW-1:0] code_in,
   output logic [QW-1:0] state_q,
   output logic          primed_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= Q_I;
         primed_q <= 1'b0;
      end else if (load) begin
         state_q  <= code_in;
         primed_q <= 1'b1;
      end
   end

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(state_q) && $stable(primed_q)));

   assert_load_takes_R6: assert property (@(posedge clk) disable iff (rst)
      load |=> (state_q == $past(code_in) && primed_q));
endmodule

// File: rtl/fdq_decide.sv
module fdq_decide
   import fdq_pkg::*;
#(
   parameter int QW = 2
) (
   input  logic          strobe,
   input  logic          primed,
   input  logic [QW-1:0] prev_q,
   input  logic [QW-1:0] next_q,
   output logic          req_up,
   output logic          req_dn
);
   localparam logic [QW-1:0] CODE_FIRST = QW'(Q_I);
   localparam logic [QW-1:0] CODE_LAST  = QW'(Q_IV);

   logic [1:0] step;
   move_e      move;

   always_comb begin
      step = quad_idx(next_q) - quad_idx(prev_q);
      move = move_e'(step);
   end

   always_comb begin
      req_up = 1'b0;
      req_dn = 1'b0;
      if (strobe && primed) begin
         unique case (move)
            MV_FWD:  req_dn = (prev_q == CODE_LAST);
            MV_BACK: req_up = (prev_q == CODE_FIRST);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fdq_pulse.sv
module fdq_pulse #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic up_in,
   input  logic dn_in,
   output logic up_out,
   output logic dn_out
);
   generate
      if (OUT_REG) begin : g_reg
         logic up_q, dn_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               up_q <= 1'b0;
               dn_q <= 1'b0;
            end else begin
               up_q <= up_in;
               dn_q <= dn_in;
            end
         end
         assign up_out = up_q;
         assign dn_out = dn_q;
      end else begin : g_comb
         assign up_out = up_in & ~rst;
         assign dn_out = dn_in & ~rst;
      end
   endgenerate
endmodule

// File: rtl/fdq_freq_det.sv
module fdq_freq_det
   import fdq_pkg::*;
#(
   parameter int QW       = 2,
   parameter bit OUT_REG  = 1'b1,
   parameter bit SWAP_DIR = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          quad_vld,
   input  logic [QW-1:0] quad_code,
   output logic          freq_up,
   output logic          freq_dn
);
   localparam int NQUAD = 1 << QW;

   generate
      if (NQUAD != 4) begin : g_bad_width
         $error("fdq_freq_det: quadrant code must be 2 bits wide");
      end
   endgenerate

   logic [QW-1:0] state_q;
   logic          primed_q;
   logic          req_up, req_dn;
   logic          pul_up, pul_dn;

   fdq_state #(.QW(QW)) u_state (
      .clk      (clk),
      .rst      (rst),
      .load     (quad_vld),
      .code_in  (quad_code),
      .state_q  (state_q),
      .primed_q (primed_q)
   );

   fdq_decide #(.QW(QW)) u_decide (
      .strobe (quad_vld),
      .primed (primed_q),
      .prev_q (state_q),
      .next_q (quad_code),
      .req_up (req_up),
      .req_dn (req_dn)
   );

   fdq_pulse #(.OUT_REG(OUT_REG)) u_pulse (
      .clk    (clk),
      .rst    (rst),
      .up_in  (req_up),
      .dn_in  (req_dn),
      .up_out (pul_up),
      .dn_out (pul_dn)
   );

   generate
      if (SWAP_DIR) begin : g_swap
         assign freq_up = pul_dn;
         assign freq_dn = pul_up;
      end else begin : g_direct
         assign freq_up = pul_up;
         assign freq_dn = pul_dn;
      end
   endgenerate

   assert_never_both_R9: assert property (@(posedge clk) disable iff (rst)
      !(freq_up && freq_dn));

   assert_single_up_R4: assert property (@(posedge clk) disable iff (rst)
      freq_up |=> !freq_up);

   assert_single_dn_R3: assert property (@(posedge clk) disable iff (rst)
      freq_dn |=> !freq_dn);

   generate
      if (OUT_REG && !SWAP_DIR) begin : g_chk_reg
         assert_first_silent_R2: assert property (@(posedge clk) disable iff (rst)
            (quad_vld && !primed_q) |=> !(freq_up || freq_dn));

         assert_hold_silent_R7: assert property (@(posedge clk) disable iff (rst)
            (quad_vld && quad_code == state_q) |=> !(freq_up || freq_dn));
      end
   endgenerate
endmodule

// File: tb/fdq_freq_det_tb.sv
`timescale 1ns/1ps
module fdq_freq_det_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       quad_vld = 1'b0;
   logic [1:0] quad_code = 2'b00;
   logic       freq_up, freq_dn;

   int n_chk = 0;
   int n_bad = 0;

   // bench model of the stored quadrant
   logic [1:0] m_state = 2'b00;
   logic       m_primed = 1'b0;
   int         cnt_up, cnt_dn;

   localparam logic [1:0] QI = 2'b00, QII = 2'b01, QIII = 2'b11, QIV = 2'b10;

   always #4 clk = ~clk;

   fdq_freq_det u_dut (
      .clk       (clk),
      .rst       (rst),
      .quad_vld  (quad_vld),
      .quad_code (quad_code),
      .freq_up   (freq_up),
      .freq_dn   (freq_dn)
   );

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {up,dn} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: count actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      quad_vld = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      m_state = QI;
      m_primed = 1'b0;
   endtask

   // Apply one strobe, check the pulse one cycle later against the model
   task automatic step(input logic [1:0] code, input string req);
      logic eu, ed;
      eu = m_primed && (m_state == QI)  && (code == QIV);
      ed = m_primed && (m_state == QIV) && (code == QI);
      @(negedge clk);
      quad_vld = 1'b1;
      quad_code = code;
      @(negedge clk);
      quad_vld = 1'b0;
      chk(req, {freq_up, freq_dn}, {eu, ed});
      if (freq_up) cnt_up++;
      if (freq_dn) cnt_dn++;
      m_state = code;
      m_primed = 1'b1;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 during reset", {freq_up, freq_dn}, 2'b00);
      rst = 1'b0;
      m_state = QI;
      m_primed = 1'b0;
      @(negedge clk);
      chk("R1 after release", {freq_up, freq_dn}, 2'b00);
   endtask

   task automatic t_first_silent();
      do_reset();
      step(QIV, "R2 first strobe IV");
      do_reset();
      step(QI, "R2 first strobe I");
      step(QIV, "R2 then I->IV is live (R4)");
   endtask

   task automatic t_down();
      do_reset();
      step(QIV, "R3 prime IV");
      step(QI, "R3 IV->I down");
      @(negedge clk);
      chk("R3 pulse lasts one cycle", {freq_up, freq_dn}, 2'b00);
   endtask

   task automatic t_up();
      do_reset();
      step(QI, "R4 prime I");
      step(QIV, "R4 I->IV up");
      @(negedge clk);
      chk("R4 pulse lasts one cycle", {freq_up, freq_dn}, 2'b00);
   endtask

   task automatic t_adjacent();
      do_reset();
      step(QI, "R5 prime");
      step(QII, "R5 I->II");
      step(QIII, "R5 II->III");
      step(QIV, "R5 III->IV");
      step(QIII, "R5 IV->III");
      step(QII, "R5 III->II");
      step(QI, "R5 II->I");
   endtask

   task automatic t_jump();
      do_reset();
      step(QIV, "R6 prime IV");
      step(QII, "R6 jump IV->II");
      step(QI, "R6 II->I after jump, silent");
      step(QIII, "R6 jump I->III");
      step(QIV, "R6 III->IV after jump, silent");
      step(QI, "R6 probe IV->I down");
   endtask

   task automatic t_hold();
      do_reset();
      step(QIV, "R7 prime IV");
      for (int i = 0; i < 4; i++) step(QIV, "R7 repeat IV");
      step(QI, "R7 IV->I still live");
      for (int i = 0; i < 3; i++) step(QI, "R7 repeat I");
   endtask

   task automatic t_nostrobe();
      do_reset();
      step(QIV, "R8 prime IV");
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         quad_code = 2'(i);
         chk("R8 code without strobe", {freq_up, freq_dn}, 2'b00);
      end
      step(QI, "R8 state still IV gives down");
   endtask

   task automatic t_rotate(input bit fwd, input int n, input int exp_pulses);
      int idx;
      logic [1:0] g;
      do_reset();
      step(QI, "R9 rotate prime");
      cnt_up = 0;
      cnt_dn = 0;
      idx = 0;
      for (int i = 0; i < n; i++) begin
         idx = fwd ? (idx + 1) % 4 : (idx + 3) % 4;
         case (idx)
            0: g = QI;
            1: g = QII;
            2: g = QIII;
            default: g = QIV;
         endcase
         step(g, "R9 rotation step");
      end
      if (fwd) begin
         chk_int("R9 forward down count", cnt_dn, exp_pulses);
         chk_int("R9 forward up count", cnt_up, 0);
      end else begin
         chk_int("R9 reverse up count", cnt_up, exp_pulses);
         chk_int("R9 reverse down count", cnt_dn, 0);
      end
   endtask

   initial begin
      cnt_up = 0;
      cnt_dn = 0;
      t_reset_state();
      t_first_silent();
      t_down();
      t_up();
      t_adjacent();
      t_jump();
      t_hold();
      t_nostrobe();
      t_rotate(1'b1, 16, 4);
      t_rotate(1'b0, 12, 3);
      t_rotate(1'b1, 7, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule